// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer with Early-Warning Interrupt

This block is the digital half of an on-chip supply monitor. Two analog comparators report whether the supply is below the reset trip point and whether it is below a higher warning trip point. Those levels are asynchronous to the clock, so the block synchronizes them first. From them it produces the system reset, the oscillator enable, a sticky power-fail flag, the interrupt request for that flag, and a wake request that brings the core out of stop mode.

At power-up the block holds the system in reset while the supply is low. Once the supply is good, it switches the oscillator on and lets a fixed number of clocks pass so the oscillator can settle. Only then does it release reset. If the supply sags below the reset trip point at any time, reset returns at once and the settling count starts again. No software action is needed for this.

The warning path sets a flag that software can read and clear through a control register. It raises an interrupt only when software has enabled it. The interrupt vector address is a fixed constant output.

Top module: `pwr_supervisor`

## Requirements
- R1: After `rst_n` is released with both comparator inputs at 1, `sys_rst_o`=1, `osc_en_o`=0, `pf_irq_o`=0, `wake_o`=0 and `ctl_rdata_o`=8'h00.
- R2: While the synchronized reset comparator reads 1 (supply low), `sys_rst_o` stays 1 and `osc_en_o` stays 0.
- R3: When `vlow_rst_i` falls to 0, `osc_en_o` rises after the third rising clock edge. Two edges are spent in the synchronizer and one in the sequencer.
- R4: `sys_rst_o` falls exactly `SETTLE_CLKS` (default 65536) clock edges after the edge on which `osc_en_o` rose, and not before.
- R5: When `vlow_rst_i` rises to 1 at any time, `sys_rst_o`=1 and `osc_en_o`=0 after the third rising edge. A new good-supply period restarts the settling count from zero.
- R6: A 0-to-1 change of the synchronized warning comparator sets the flag. The flag reads at `ctl_rdata_o` bit 4, three edges after `vlow_warn_i` rises, whatever the enable holds.
- R7: A register write (`ctl_we_i`=1) loads the enable from `ctl_wdata_i` bit 5. The write clears the flag only if bit 4 is 0; writing 1 to bit 4 leaves the flag as it was. The read value is {2'b00, enable, flag, 4'b0000}.
- R8: `pf_irq_o` is 1 exactly when both the flag and the enable are 1.
- R9: If a warning event and a clearing write take effect on the same edge, the flag ends up set.
- R10: A warning event while the enable is 1 and `bgs_i` is 1 drives `wake_o` high for exactly one cycle, on the same edge the flag is set. Otherwise `wake_o` stays 0.
- R11: `pf_vector_o` is constantly 16'h0033.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous initial reset, active low |
| vlow_rst_i | input | 1 | Raw comparator: supply below reset trip point |
| vlow_warn_i | input | 1 | Raw comparator: supply below warning trip point |
| bgs_i | input | 1 | Band-gap select, allows a stop-mode wake |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Write data: bit 5 enable, bit 4 flag (0 clears) |
| ctl_rdata_o | output | 8 | Read data: bit 5 enable, bit 4 flag |
| sys_rst_o | output | 1 | System reset, active high |
| osc_en_o | output | 1 | Oscillator enable |
| pf_irq_o | output | 1 | Power-fail interrupt request |
| wake_o | output | 1 | One-cycle stop-mode wake request |
| pf_vector_o | output | 16 | Interrupt vector address |

## Verification
Every result arrives a fixed number of edges after its cause:
- A comparator change reaches the oscillator enable, the reset, the flag and the wake pulse three edges after it is driven.
- Reset release comes a further `SETTLE_CLKS` edges after the oscillator enable rises.
- A register write shows on the read port one edge after it is driven.

When the bench applies a stimulus, it queues each expected value tagged with its due cycle. The monitor compares each queued value only in the cycle it is due, sampling between edges. It also checks the cycle just before each transition, so an early or late result is caught as well as a wrong one.

// File: rtl/pwr_supervisor_pkg.sv
package pwr_supervisor_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_RUN    = 2'd2
    } seq_state_e;

    localparam int CTL_IE_BIT   = 5;
    localparam int CTL_FLAG_BIT = 4;
    localparam logic [15:0] PF_VECTOR = 16'h0033;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_settle_seq.sv
module pwr_settle_seq
    import pwr_supervisor_pkg::*;
#(
    parameter int SETTLE_CLKS = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_i,
    output logic sys_rst_o,
    output logic osc_en_o
);
    localparam int CNT_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CLKS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (vlow_i) begin
            r_d.state = SEQ_HOLD;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                SEQ_HOLD: begin
                    r_d.state = SEQ_SETTLE;
                    r_d.cnt   = '0;
                end
                SEQ_SETTLE: begin
                    if (r_q.cnt == CNT_LAST) r_d.state = SEQ_RUN;
                    else                     r_d.cnt   = r_q.cnt + 1'b1;
                end
                default: r_d.state = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: SEQ_HOLD, cnt: '0};
        else        r_q <= r_d;
    end

    assign sys_rst_o = (r_q.state != SEQ_RUN);
    assign osc_en_o  = (r_q.state != SEQ_HOLD);

    // R2
    osc_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> sys_rst_o);
    // R5
    reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_i |=> (sys_rst_o && !osc_en_o));
    // R4
    release_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> $past(osc_en_o));
endmodule

// File: rtl/pwr_fail_flag.sv
module pwr_fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_i,
    input  logic bgs_i,
    input  logic wr_en_i,
    input  logic wr_ie_i,
    input  logic wr_flag_i,
    output logic flag_o,
    output logic ie_o,
    output logic wake_o
);
    typedef struct packed {
        logic prev;
        logic flag;
        logic ie;
        logic wake;
    } pf_regs_t;

    pf_regs_t r_d, r_q;
    logic event_w;
    logic clear_w;

    always_comb begin
        event_w = warn_i && !r_q.prev;
        clear_w = wr_en_i && !wr_flag_i;
        r_d      = r_q;
        r_d.prev = warn_i;
        if (wr_en_i) r_d.ie = wr_ie_i;
        r_d.flag = event_w || (r_q.flag && !clear_w);
        r_d.wake = event_w && r_q.ie && bgs_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{prev: 1'b1, flag: 1'b0, ie: 1'b0, wake: 1'b0};
        else        r_q <= r_d;
    end

    assign flag_o = r_q.flag;
    assign ie_o   = r_q.ie;
    assign wake_o = r_q.wake;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_en_i && !wr_flag_i)) |=> flag_o);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_i && !r_q.prev) |=> flag_o);
    // R10
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwr_supervisor_pkg::*;
#(
    parameter int SETTLE_CLKS = 65536,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vlow_rst_i,
    input  logic        vlow_warn_i,
    input  logic        bgs_i,
    input  logic        ctl_we_i,
    input  logic [7:0]  ctl_wdata_i,
    output logic [7:0]  ctl_rdata_o,
    output logic        sys_rst_o,
    output logic        osc_en_o,
    output logic        pf_irq_o,
    output logic        wake_o,
    output logic [15:0] pf_vector_o
);
    logic [1:0] cmp_sync;
    logic       flag_w;
    logic       ie_w;
    logic       unused_wdata;

    assign unused_wdata = ^{ctl_wdata_i[7:6], ctl_wdata_i[3:0]};

    pwr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({vlow_warn_i, vlow_rst_i}),
        .sync_o  (cmp_sync)
    );

    pwr_settle_seq #(.SETTLE_CLKS(SETTLE_CLKS)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vlow_i    (cmp_sync[0]),
        .sys_rst_o (sys_rst_o),
        .osc_en_o  (osc_en_o)
    );

    pwr_fail_flag flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .warn_i    (cmp_sync[1]),
        .bgs_i     (bgs_i),
        .wr_en_i   (ctl_we_i),
        .wr_ie_i   (ctl_wdata_i[CTL_IE_BIT]),
        .wr_flag_i (ctl_wdata_i[CTL_FLAG_BIT]),
        .flag_o    (flag_w),
        .ie_o      (ie_w),
        .wake_o    (wake_o)
    );

    always_comb begin
        ctl_rdata_o               = '0;
        ctl_rdata_o[CTL_IE_BIT]   = ie_w;
        ctl_rdata_o[CTL_FLAG_BIT] = flag_w;
    end

    assign pf_irq_o    = flag_w && ie_w;
    assign pf_vector_o = PF_VECTOR;

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_irq_o |-> (ctl_rdata_o[CTL_IE_BIT] && ctl_rdata_o[CTL_FLAG_BIT]));
    // R10
    wake_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> pf_irq_o);
endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb_top;
    localparam int N = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vlow_rst = 1'b1;
    logic        vlow_warn = 1'b1;
    logic        bgs = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        sys_rst, osc_en, irq, wake;
    logic [15:0] vec;

    always #2.5 clk = ~clk;

    pwr_supervisor #(.SETTLE_CLKS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .vlow_rst_i(vlow_rst), .vlow_warn_i(vlow_warn),
        .bgs_i(bgs), .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_rdata_o(rdata),
        .sys_rst_o(sys_rst), .osc_en_o(osc_en), .pf_irq_o(irq), .wake_o(wake),
        .pf_vector_o(vec)
    );

    typedef struct {
        int    due;
        int    sig;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sample(int sig);
        case (sig)
            0: return int'(sys_rst);
            1: return int'(osc_en);
            2: return int'(irq);
            3: return int'(wake);
            4: return int'(rdata);
            default: return int'(vec);
        endcase
    endfunction

    task automatic expect_at(int k, int sig, int exp, string req);
        item_t it;
        int pos;
        it.due = cyc + k; it.sig = sig; it.exp = exp; it.req = req;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > it.due) begin pos = i; break; end
        end
        q.insert(pos, it);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [7:0] d);
        we = 1'b1; wdata = d;
        tick(1);
        we = 1'b0;
    endtask

    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int act;
            it = q.pop_front();
            act = sample(it.sig);
            compared++;
            if (it.due < cyc || act !== it.exp) begin
                mismatched++;
                $display("FAIL %s sig%0d cycle %0d: actual %h expected %h",
                         it.req, it.sig, it.due, act, it.exp);
            end
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_at(1, 0, 1, "R1"); expect_at(1, 1, 0, "R1");
        expect_at(1, 2, 0, "R1"); expect_at(1, 3, 0, "R1");
        expect_at(1, 4, 8'h00, "R1"); expect_at(1, 5, 16'h0033, "R11");
        expect_at(6, 0, 1, "R2"); expect_at(6, 1, 0, "R2");
        tick(8);
        // R3: supply becomes good
        vlow_rst = 1'b0;
        expect_at(2, 1, 0, "R3"); expect_at(3, 1, 1, "R3");
        expect_at(3, 0, 1, "R3");
        tick(100);
        // R5: dip during settling
        vlow_rst = 1'b1;
        expect_at(2, 1, 1, "R5"); expect_at(3, 1, 0, "R5");
        expect_at(3, 0, 1, "R5");
        tick(6);
        // R4: fresh count after restart
        vlow_rst = 1'b0;
        expect_at(3, 1, 1, "R4");
        expect_at(2 + N, 0, 1, "R4"); expect_at(3 + N, 0, 0, "R4");
        tick(N + 10);
        // R6: warning event with enable clear
        vlow_warn = 1'b0;
        tick(5);
        vlow_warn = 1'b1;
        expect_at(2, 4, 8'h00, "R6"); expect_at(3, 4, 8'h10, "R6");
        expect_at(3, 2, 0, "R8"); expect_at(3, 3, 0, "R10");
        tick(6);
        // R7: write 1 to flag bit keeps it, enable set
        reg_write(8'h30);
        expect_at(0 + 1, 4, 8'h30, "R7"); expect_at(1, 2, 1, "R8");
        tick(2);
        // R7: write 0 clears the flag
        reg_write(8'h20);
        expect_at(1, 4, 8'h20, "R7"); expect_at(1, 2, 0, "R8");
        tick(2);
        // R10: wake pulse with band-gap select
        bgs = 1'b1;
        vlow_warn = 1'b0;
        tick(5);
        vlow_warn = 1'b1;
        expect_at(2, 3, 0, "R10"); expect_at(3, 3, 1, "R10");
        expect_at(4, 3, 0, "R10"); expect_at(3, 2, 1, "R8");
        tick(6);
        reg_write(8'h20);
        expect_at(1, 4, 8'h20, "R7");
        tick(2);
        // R9: clear and event on the same edge
        bgs = 1'b0;
        vlow_warn = 1'b0;
        tick(5);
        vlow_warn = 1'b1;
        expect_at(3, 4, 8'h30, "R9"); expect_at(3, 3, 0, "R10");
        tick(2);
        reg_write(8'h20);
        tick(4);
        // R5: drop while running
        vlow_rst = 1'b1;
        expect_at(2, 0, 0, "R5"); expect_at(3, 0, 1, "R5");
        expect_at(3, 1, 0, "R5"); expect_at(3, 5, 16'h0033, "R11");
        tick(8);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule